// File: doc/BRIEF.md
# Dual Programmable Tick Generator

This block derives two independent clock-enable strobes, called A and B, from the master clock. They are meant for the period counters of a pulse-width modulation unit. Each generator takes the strobe of a shared power-of-two prescaler and divides it again by an 8-bit linear divisor. A tick therefore arrives every 2^exponent × divisor master-clock cycles. The outputs are one-cycle enables, not gated clocks, so everything downstream stays in the master clock domain.

A single 32-bit configuration word sets up both generators. The low 16 bits program A and the high 16 bits program B, and the two halves share one layout. When a half changes, only that generator restarts. The raw prescaler strobes for every exponent from 0 to 10 are also brought out, so channels can count on them directly.

Top module: `dual_tick_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `tick_a` and `tick_b` are 0. During reset `pre_tick` equals 1: only bit 0 is set.
- R2: Bit k of `pre_tick`, for k from 0 to 10, is high for one cycle in every 2^k cycles. Bit 0 is high in every cycle.
- R3: The low half of `mode_word` programs generator A. Bits 7:0 hold the divisor d and bits 11:8 hold the exponent e. With 1 ≤ d ≤ 255 and e ≤ 10, consecutive rising ticks on `tick_a` are exactly 2^e × d cycles apart.
- R4: Bits 23:16 (divisor) and 27:24 (exponent) of `mode_word` program generator B with the same rule, and B's period is observed on `tick_b`.
- R5: A divisor of 0 stops the generator: it produces no ticks. An all-zero half is a special case of this.
- R6: An exponent above 10 stops the generator: it produces no ticks.
- R7: A tick is high for exactly one cycle, except when the period is 1 (e = 0, d = 1). With period 1 the strobe stays high.
- R8: A change in the exponent or divisor of one half restarts only that generator's divider. The other generator's tick spacing is unaffected, including across the cycle of the change.
- R9: Bits 15:12 and 31:28 of `mode_word` are ignored. Changing them neither alters a generator's period nor restarts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_word | input | 32 | Configuration word. Low half programs A, high half programs B |
| tick_a | output | 1 | Clock-enable strobe of generator A |
| tick_b | output | 1 | Clock-enable strobe of generator B |
| pre_tick | output | 11 | Prescaler strobes. Bit k fires every 2^k cycles |

## Verification
A configuration write to one half can land in the same cycle as the other generator's divider step or tick. A write can also land in the same cycle as the generator's own prescale strobe. The bench provokes the first case by waiting for a tick on B, then rewriting A at the next falling edge, and requiring the next B interval to equal B's programmed period exactly. A second probe rewrites only ignored bits of A six cycles after an A tick, when A's divider is part-way through a count. A false restart at that point would stretch the interval from 12 to 16 cycles, so the measured interval separates the two outcomes.

// File: rtl/tick_gen_pkg.sv
package tick_gen_pkg;
    localparam int EXP_MAX  = 10;
    localparam int DIV_W    = 8;
    localparam int EXP_W    = $clog2(EXP_MAX + 1);
    localparam int HALF_W   = 16;
    localparam int SPARE_W  = HALF_W - DIV_W - EXP_W;
    localparam int NUM_GEN  = 2;
    localparam int WORD_W   = HALF_W * NUM_GEN;

    typedef struct packed {
        logic [SPARE_W-1:0] spare;
        logic [EXP_W-1:0]   exp;
        logic [DIV_W-1:0]   div;
    } half_cfg_t;

    function automatic logic cfg_active(half_cfg_t c);
        return (c.div != '0) && (c.exp <= EXP_W'(EXP_MAX));
    endfunction

    function automatic logic cfg_differs(half_cfg_t a, half_cfg_t b);
        return (a.exp != b.exp) || (a.div != b.div);
    endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
    import tick_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic [EXP_MAX:0] pre_tick
);
    logic [EXP_MAX-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end

    assign pre_tick[0] = 1'b1;

    for (genvar k = 1; k <= EXP_MAX; k++) begin : g_stage
        assign pre_tick[k] = &cnt[k-1:0];

        // R2: a slower strobe only fires together with the next faster one
        assert_pre_nest_R2: assert property (@(posedge clk) disable iff (rst)
            pre_tick[k] |-> pre_tick[k-1]);
        // R2: strobes above 2^0 are one cycle wide
        assert_pre_pulse_R2: assert property (@(posedge clk) disable iff (rst)
            pre_tick[k] |=> !pre_tick[k]);
    end
endmodule

// File: rtl/tick_divider.sv
module tick_divider
    import tick_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  half_cfg_t        cfg_in,
    input  logic [EXP_MAX:0] pre_tick,
    output logic             tick
);
    half_cfg_t        cfg_q;
    logic [DIV_W-1:0] div_cnt;
    logic             changed;
    logic             step;
    logic             active;
    logic             wrap;

    always_comb changed = cfg_differs(cfg_in, cfg_q);
    always_comb active  = cfg_active(cfg_q);
    always_comb wrap    = (div_cnt == cfg_q.div - DIV_W'(1));

    always_comb begin
        step = 1'b0;
        for (int k = 0; k <= EXP_MAX; k++) begin
            if (cfg_q.exp == EXP_W'(k)) step = pre_tick[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            div_cnt <= '0;
            tick    <= 1'b0;
        end else if (changed) begin
            cfg_q.exp   <= cfg_in.exp;
            cfg_q.div   <= cfg_in.div;
            cfg_q.spare <= '0;
            div_cnt     <= '0;
            tick        <= 1'b0;
        end else if (active && step) begin
            if (wrap) begin
                div_cnt <= '0;
                tick    <= 1'b1;
            end else begin
                div_cnt <= div_cnt + 1'b1;
                tick    <= 1'b0;
            end
        end else begin
            tick <= 1'b0;
        end
    end

    assert_off_silent_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.div == '0) |=> !tick);
    assert_exp_range_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.exp > EXP_W'(EXP_MAX)) |=> !tick);
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (tick && !(cfg_q.exp == '0 && cfg_q.div == DIV_W'(1))) |=> !tick);
    assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
        changed |=> (!tick && div_cnt == '0));
endmodule

// File: rtl/dual_tick_gen.sv
module dual_tick_gen
    import tick_gen_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [WORD_W-1:0]   mode_word,
    output logic                tick_a,
    output logic                tick_b,
    output logic [EXP_MAX:0]    pre_tick
);
    logic [NUM_GEN-1:0] ticks;

    tick_prescaler u_pre (
        .clk      (clk),
        .rst      (rst),
        .pre_tick (pre_tick)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        half_cfg_t half;
        assign half = half_cfg_t'(mode_word[g*HALF_W +: HALF_W]);

        tick_divider u_div (
            .clk      (clk),
            .rst      (rst),
            .cfg_in   (half),
            .pre_tick (pre_tick),
            .tick     (ticks[g])
        );
    end

    assign tick_a = ticks[0];
    assign tick_b = ticks[1];

    // R1: no strobe right after reset, before any configuration is taken
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!tick_a && !tick_b));
endmodule

// File: tb/test_dual_tick_gen.sv
module test_dual_tick_gen;
    localparam time CLK_HALF = 10ns;
    localparam int  TIMEOUT  = 5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] mode_word = '0;
    logic        tick_a, tick_b;
    logic [10:0] pre_tick;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #CLK_HALF clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dual_tick_gen i_dual_tick_gen (
        .clk       (clk),
        .rst       (rst),
        .mode_word (mode_word),
        .tick_a    (tick_a),
        .tick_b    (tick_b),
        .pre_tick  (pre_tick)
    );

    typedef struct {
        int    sel;
        int    period;
        string tag;
    } item_t;
    item_t exp_q[$];

    function automatic logic sig(int sel);
        if (sel == 0) return tick_a;
        if (sel == 1) return tick_b;
        return pre_tick[sel-2];
    endfunction

    task automatic chk(bit ok, string tag, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // waits at falling edges for a high strobe; returns cycle stamp or -1
    task automatic wait_high(int sel, output int stamp);
        stamp = -1;
        for (int i = 0; i < TIMEOUT; i++) begin
            @(negedge clk);
            if (sig(sel)) begin
                stamp = cyc;
                break;
            end
        end
    endtask

    // monitor: pops expected periods and measures two consecutive strobes
    initial begin
        forever begin
            int t0, t1;
            item_t it;
            wait (exp_q.size() > 0);
            it = exp_q[0];
            wait_high(it.sel, t0);
            wait_high(it.sel, t1);
            if (t0 < 0 || t1 < 0) chk(0, it.tag, -1, it.period);
            else                  chk(t1 - t0 == it.period, it.tag, t1 - t0, it.period);
            void'(exp_q.pop_front());
        end
    end

    // driver: pushes the expected period and waits for the monitor
    task automatic expect_period(int sel, int period, string tag);
        item_t it;
        it.sel = sel; it.period = period; it.tag = tag;
        exp_q.push_back(it);
        wait (exp_q.size() == 0);
    endtask

    task automatic expect_silent(int sel, int cycles, string tag);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (sig(sel)) seen++;
        end
        chk(seen == 0, tag, seen, 0);
    endtask

    task automatic set_mode(logic [31:0] w);
        @(negedge clk);
        mode_word = w;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_HALF * 2 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int t0, t1;
        mode_word = 32'h0001_0001;
        repeat (3) @(negedge clk);
        // R1: quiet outputs and only the 2^0 prescale strobe during reset
        chk(tick_a == 1'b0, "R1 tick_a in reset", tick_a, 0);
        chk(tick_b == 1'b0, "R1 tick_b in reset", tick_b, 0);
        chk(pre_tick == 11'h001, "R1 pre_tick in reset", pre_tick, 1);
        rst = 1'b0;
        @(negedge clk);
        chk(tick_a == 1'b0, "R1 tick_a after reset", tick_a, 0);
        mode_word = '0;

        // R2: prescaler strobe spacing
        expect_period(2, 1, "R2 pre 2^0");
        expect_period(5, 8, "R2 pre 2^3");
        expect_period(12, 1024, "R2 pre 2^10");

        // R3: generator A
        set_mode(32'h0000_0001);
        expect_period(0, 1, "R3 A e0 d1");
        set_mode(32'h0000_0203);
        expect_period(0, 12, "R3 A e2 d3");

        // R4: generator B
        set_mode(32'h0A01_0000);
        expect_period(1, 1024, "R4 B e10 d1");
        set_mode(32'h01FF_0000);
        expect_period(1, 510, "R4 B e1 d255");

        // both running together
        set_mode(32'h0305_0307);
        expect_period(0, 56, "R3 A e3 d7 with B on");
        expect_period(1, 40, "R4 B e3 d5 with A on");

        // R7: strobe drops after one cycle
        wait_high(0, t0);
        @(negedge clk);
        chk(tick_a == 1'b0, "R7 tick_a one cycle wide", tick_a, 0);

        // R5: zero divisor, and an all-zero half
        set_mode(32'h0000_0300);
        expect_silent(0, 2000, "R5 A div 0");
        expect_silent(1, 2000, "R5 B all-zero half");

        // R6: exponent above 10
        set_mode(32'h0F01_0B05);
        expect_silent(0, 3000, "R6 A exp 11");
        expect_silent(1, 3000, "R6 B exp 15");

        // R8: rewriting A in a B tick cycle leaves B spacing intact
        set_mode(32'h0305_0203);
        wait_high(1, t0);
        wait_high(1, t0);
        mode_word = 32'h0305_0105;
        wait_high(1, t1);
        chk(t0 >= 0 && t1 - t0 == 40, "R8 B interval across A rewrite", t1 - t0, 40);
        expect_period(0, 10, "R8 A restarted with new setting");

        // R9: ignored bits of A, changed mid-count, cause no restart
        set_mode(32'h0305_0203);
        wait_high(0, t0);
        wait_high(0, t0);
        repeat (6) @(negedge clk);
        mode_word = 32'h0305_F203;
        wait_high(0, t1);
        chk(t0 >= 0 && t1 - t0 == 12, "R9 spare bits ignored", t1 - t0, 12);
        set_mode(32'hF305_F203);
        expect_period(1, 40, "R9 B spare bits ignored");

        finish_run();
    end
endmodule